// File: doc/BRIEF.md
# Status Channel Calendar Frame Generator

This block produces the 2-bit flow-control status stream that a packet receiver returns to its transmitter. A calendar maps each slot to a logical port. Every clock the block emits one 2-bit word. A frame opens with a framing word of `11`. An optional calendar-selection word may follow it. The frame then carries the port status of each calendar slot, and the whole calendar pass is repeated a programmed number of times. The frame closes with an inverted diagonal-parity (DIP-2) word.

Two calendars are held, each with its own slot list, length and repeat count, and both are written through a simple write port. Each frame runs on a private working copy of one calendar. That copy is taken on the framing word, so a write changes nothing until the next frame. A loss-of-sync input forces an idle stream of framing words, and the frame sequence restarts when it drops.

Top module: `sts_cal_gen`

## Requirements
- R1: While and after reset, `stat_o` is `11`. The reset configuration of both calendars is: length field 7 (8 slots), repeat field 1 (2 passes), entry i holding port i mod NUM_PORTS. Calendar 0 is active.
- R2: A slot word equals the status of the port named by the slot entry. The status of port p is `port_stat_i[2p+1:2p]`.
- R3: One calendar pass covers slots 0 to L, where L is the 7-bit length field (L+1 slots).
- R4: The pass is emitted M+1 times in a row, where M is the 8-bit repeat field.
- R5: A frame is, in order: framing word `11`, an optional selection word, the (M+1)·(L+1) slot words, and the parity word. The next framing word follows directly.
- R6: Parity starts at `00`. For each selection word and slot word w of the frame, acc = {acc[0],acc[1]} ^ w. The parity word is ~acc.
- R7: If `csw_en_i` is high on the framing cycle, the next word is {0, c} and the frame uses calendar c = `cal_sel_i`. If it is low, no selection word is sent and the active calendar is kept.
- R8: The two calendars hold independent entries, lengths and repeat counts. Write field codes are: 0 repeat (data[7:0]), 1 length (data[6:0]), 2 entry at `wr_idx_i` (data[PORT_W-1:0]).
- R9: When `lvds_mode_i` is high on the framing cycle, the frame uses length field L|3, so its slot count is a multiple of 4.
- R10: A write takes effect at the first framing cycle after it. A write on the framing cycle itself only applies to the following frame.
- R11: While `los_i` is high, `stat_o` is `11` on every cycle. On release, the stream restarts with a framing word.
- R12: A write with field code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_cal_i | input | 1 | Calendar addressed by the write |
| wr_field_i | input | 2 | Field code (0 repeat, 1 length, 2 entry, 3 none) |
| wr_idx_i | input | LEN_W | Slot index for entry writes |
| wr_data_i | input | 8 | Write data |
| port_stat_i | input | 2*NUM_PORTS | Per-port 2-bit status |
| cal_sel_i | input | 1 | Calendar requested for the next frame |
| csw_en_i | input | 1 | Enables the selection word and calendar switching |
| lvds_mode_i | input | 1 | Differential mode: rounds length up to 4n-1 |
| los_i | input | 1 | Loss of sync: hold framing words |
| stat_o | output | 2 | Status stream |

## Verification
The collision that matters is a register write on the same cycle as the framing word, where the snapshot of the working calendar is taken. The bench drives a write whose strobe lands exactly on a framing edge. It then expects that frame to show the old values and the frame after it to show the new ones. Mid-frame writes, writes to the inactive calendar and null writes are mixed in with random configurations. Every word of every frame is compared against a frame built in the bench.

// File: rtl/sts_cal_pkg.sv
package sts_cal_pkg;
  localparam int REP_W  = 8;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    FLD_REP  = 2'b00,
    FLD_LEN  = 2'b01,
    FLD_ENT  = 2'b10,
    FLD_NONE = 2'b11
  } wr_field_e;

  typedef enum logic [1:0] {
    ST_FRAME = 2'b00,
    ST_SEL   = 2'b01,
    ST_SLOT  = 2'b10,
    ST_DIP   = 2'b11
  } seq_state_e;
endpackage

// File: rtl/sts_cal_regs.sv
module sts_cal_regs
  import sts_cal_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int MAX_SLOTS = 128,
  localparam int LEN_W  = $clog2(MAX_SLOTS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_cal_i,
  input  logic [1:0]        wr_field_i,
  input  logic [LEN_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              csw_en_i,
  input  logic              cal_sel_i,
  input  logic              lvds_mode_i,
  input  logic [LEN_W-1:0]  rd_slot_i,
  output logic              work_cal_o,
  output logic [LEN_W-1:0]  work_len_o,
  output logic [REP_W-1:0]  work_rep_o,
  output logic [PORT_W-1:0] rd_port_o
);
  localparam int NCAL = 2;

  logic [REP_W-1:0]  sh_rep [NCAL];
  logic [LEN_W-1:0]  sh_len [NCAL];
  logic [PORT_W-1:0] sh_ent [NCAL][MAX_SLOTS];

  for (genvar c = 0; c < NCAL; c++) begin : g_cal
    logic [REP_W-1:0]  rep_q;
    logic [LEN_W-1:0]  len_q;
    logic [PORT_W-1:0] ent_q [MAX_SLOTS];
    logic              sel;

    assign sel = wr_en_i && (wr_cal_i == 1'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rep_q <= REP_W'(1);
        len_q <= LEN_W'(7);
        for (int i = 0; i < MAX_SLOTS; i++) ent_q[i] <= PORT_W'(i % NUM_PORTS);
      end else if (sel) begin
        case (wr_field_e'(wr_field_i))
          FLD_REP: rep_q <= wr_data_i[REP_W-1:0];
          FLD_LEN: len_q <= wr_data_i[LEN_W-1:0];
          FLD_ENT: ent_q[wr_idx_i] <= wr_data_i[PORT_W-1:0];
          default: ;
        endcase
      end
    end

    assign sh_rep[c] = rep_q;
    assign sh_len[c] = len_q;
    assign sh_ent[c] = ent_q;
  end

  logic              work_cal_q;
  logic [LEN_W-1:0]  work_len_q;
  logic [REP_W-1:0]  work_rep_q;
  logic [PORT_W-1:0] work_ent_q [MAX_SLOTS];
  logic              nxt_cal;
  logic [LEN_W-1:0]  nxt_len;

  assign nxt_cal = csw_en_i ? cal_sel_i : work_cal_q;
  // differential mode rounds the slot count up to a multiple of 4
  assign nxt_len = lvds_mode_i ? (sh_len[nxt_cal] | LEN_W'(3)) : sh_len[nxt_cal];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_cal_q <= 1'b0;
      work_len_q <= LEN_W'(7);
      work_rep_q <= REP_W'(1);
      for (int i = 0; i < MAX_SLOTS; i++) work_ent_q[i] <= PORT_W'(i % NUM_PORTS);
    end else if (load_i) begin
      work_cal_q <= nxt_cal;
      work_len_q <= nxt_len;
      work_rep_q <= sh_rep[nxt_cal];
      work_ent_q <= sh_ent[nxt_cal];
    end
  end

  assign work_cal_o = work_cal_q;
  assign work_len_o = work_len_q;
  assign work_rep_o = work_rep_q;
  assign rd_port_o  = work_ent_q[rd_slot_i];
endmodule

// File: rtl/sts_cal_dip.sv
module sts_cal_dip (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [1:0] word_i,
  output logic [1:0] parity_o
);
  logic [1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= 2'b00;
    else if (clr_i)  acc_q <= 2'b00;
    else if (en_i)   acc_q <= {acc_q[0], acc_q[1]} ^ word_i;
  end

  assign parity_o = ~acc_q;
endmodule

// File: rtl/sts_cal_seq.sv
module sts_cal_seq
  import sts_cal_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             los_i,
  input  logic             csw_en_i,
  input  logic             work_cal_i,
  input  logic [LEN_W-1:0] work_len_i,
  input  logic [REP_W-1:0] work_rep_i,
  input  logic [1:0]       slot_word_i,
  output logic             load_o,
  output logic [LEN_W-1:0] slot_o,
  output seq_state_e       state_o,
  output logic [1:0]       stat_o
);
  seq_state_e       state_q;
  logic [LEN_W-1:0] slot_q;
  logic [REP_W-1:0] rep_q;
  logic [1:0]       stat_q;
  logic [1:0]       word_d;
  logic [1:0]       parity;
  logic             dip_en;

  assign load_o = (state_q == ST_FRAME) && !los_i;
  assign dip_en = !los_i && ((state_q == ST_SEL) || (state_q == ST_SLOT));

  sts_cal_dip u_dip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load_o || los_i),
    .en_i     (dip_en),
    .word_i   (word_d),
    .parity_o (parity)
  );

  always_comb begin
    case (state_q)
      ST_SEL:  word_d = {1'b0, work_cal_i};
      ST_SLOT: word_d = slot_word_i;
      ST_DIP:  word_d = parity;
      default: word_d = 2'b11;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FRAME;
      stat_q  <= 2'b11;
      slot_q  <= '0;
      rep_q   <= '0;
    end else if (los_i) begin
      state_q <= ST_FRAME;
      stat_q  <= 2'b11;
      slot_q  <= '0;
      rep_q   <= '0;
    end else begin
      stat_q <= word_d;
      case (state_q)
        ST_FRAME: begin
          slot_q  <= '0;
          rep_q   <= '0;
          state_q <= csw_en_i ? ST_SEL : ST_SLOT;
        end
        ST_SEL: state_q <= ST_SLOT;
        ST_SLOT: begin
          if (slot_q == work_len_i) begin
            slot_q <= '0;
            if (rep_q == work_rep_i) state_q <= ST_DIP;
            else                     rep_q   <= rep_q + REP_W'(1);
          end else begin
            slot_q <= slot_q + LEN_W'(1);
          end
        end
        default: state_q <= ST_FRAME;
      endcase
    end
  end

  assign slot_o  = slot_q;
  assign state_o = state_q;
  assign stat_o  = stat_q;
endmodule

// File: rtl/sts_cal_gen.sv
module sts_cal_gen
  import sts_cal_pkg::*;
#(
  parameter int NUM_PORTS = 16,
  parameter int MAX_SLOTS = 128,
  localparam int LEN_W  = $clog2(MAX_SLOTS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   wr_cal_i,
  input  logic [1:0]             wr_field_i,
  input  logic [LEN_W-1:0]       wr_idx_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [2*NUM_PORTS-1:0] port_stat_i,
  input  logic                   cal_sel_i,
  input  logic                   csw_en_i,
  input  logic                   lvds_mode_i,
  input  logic                   los_i,
  output logic [1:0]             stat_o
);
  logic              load_w;
  logic              work_cal;
  logic [LEN_W-1:0]  work_len;
  logic [REP_W-1:0]  work_rep;
  logic [LEN_W-1:0]  slot_idx;
  logic [PORT_W-1:0] rd_port;
  logic [1:0]        slot_word;
  seq_state_e        seq_state;

  sts_cal_regs #(
    .NUM_PORTS (NUM_PORTS),
    .MAX_SLOTS (MAX_SLOTS)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_cal_i    (wr_cal_i),
    .wr_field_i  (wr_field_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .load_i      (load_w),
    .csw_en_i    (csw_en_i),
    .cal_sel_i   (cal_sel_i),
    .lvds_mode_i (lvds_mode_i),
    .rd_slot_i   (slot_idx),
    .work_cal_o  (work_cal),
    .work_len_o  (work_len),
    .work_rep_o  (work_rep),
    .rd_port_o   (rd_port)
  );

  assign slot_word = port_stat_i[{rd_port, 1'b0} +: 2];

  sts_cal_seq #(
    .LEN_W (LEN_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .los_i       (los_i),
    .csw_en_i    (csw_en_i),
    .work_cal_i  (work_cal),
    .work_len_i  (work_len),
    .work_rep_i  (work_rep),
    .slot_word_i (slot_word),
    .load_o      (load_w),
    .slot_o      (slot_idx),
    .state_o     (seq_state),
    .stat_o      (stat_o)
  );
endmodule

// File: rtl/sts_cal_gen_chk.sv
module sts_cal_gen_chk
  import sts_cal_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             los_i,
  input logic             lvds_mode_i,
  input logic             load_i,
  input seq_state_e       state_i,
  input logic [1:0]       stat_i,
  input logic [LEN_W-1:0] slot_i,
  input logic [LEN_W-1:0] work_len_i,
  input logic [REP_W-1:0] work_rep_i
);
  p_los_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |=> stat_i == 2'b11);

  p_frame_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FRAME) |=> stat_i == 2'b11);

  p_dip_then_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DIP && !los_i) |=> state_i == ST_FRAME);

  p_sel_msb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SEL && !los_i) |=> stat_i[1] == 1'b0);

  p_slot_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SLOT) |-> slot_i <= work_len_i);

  p_lvds_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && lvds_mode_i) |=> work_len_i[1:0] == 2'b11);

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(work_len_i) && $stable(work_rep_i)));
endmodule

bind sts_cal_gen sts_cal_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .los_i       (los_i),
  .lvds_mode_i (lvds_mode_i),
  .load_i      (load_w),
  .state_i     (seq_state),
  .stat_i      (stat_o),
  .slot_i      (slot_idx),
  .work_len_i  (work_len),
  .work_rep_i  (work_rep)
);

// File: tb/sts_cal_gen_tb_top.sv
`timescale 1ns/1ps
module sts_cal_gen_tb_top;
  localparam int NP = 16;
  localparam int MS = 128;
  localparam int LW = 7;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0;
  logic            wr_cal_i = 1'b0;
  logic [1:0]      wr_field_i = 2'b00;
  logic [LW-1:0]   wr_idx_i = '0;
  logic [7:0]      wr_data_i = '0;
  logic [2*NP-1:0] port_stat_i = '0;
  logic            cal_sel_i = 1'b0;
  logic            csw_en_i = 1'b0;
  logic            lvds_mode_i = 1'b0;
  logic            los_i = 1'b0;
  logic [1:0]      stat_o;

  always #4 clk_i = ~clk_i;

  sts_cal_gen #(.NUM_PORTS(NP), .MAX_SLOTS(MS)) dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_cal_i, .wr_field_i, .wr_idx_i, .wr_data_i,
    .port_stat_i, .cal_sel_i, .csw_en_i, .lvds_mode_i, .los_i, .stat_o
  );

  int n_tests = 0;
  int n_fail  = 0;
  int m_len [2];
  int m_rep [2];
  int m_ent [2][MS];
  int m_cur = 0;
  logic [1:0] m_stat [NP];

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string req, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic void mdl_wr(int c, int fld, int idx, int data);
    case (fld)
      0: m_rep[c] = data & 255;
      1: m_len[c] = data & 127;
      2: m_ent[c][idx] = data & (NP - 1);
      default: ;
    endcase
  endfunction

  task automatic do_wr(int c, int fld, int idx, int data);
    wr_en_i = 1'b1; wr_cal_i = c[0]; wr_field_i = fld[1:0];
    wr_idx_i = idx[LW-1:0]; wr_data_i = data[7:0];
    mdl_wr(c, fld, idx, data);
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic drive_stat();
    for (int p = 0; p < NP; p++) port_stat_i[2*p +: 2] = m_stat[p];
  endtask

  // act_* describe one write strobed before the edge of word act_w in frame act_f
  task automatic run_stream(input int nfr, input bit csw, input bit sel, input bit lvds,
                            input int act_f, input int act_w, input int act_c,
                            input int act_fld, input int act_i, input int act_d, input string tag);
    logic [1:0] ew [$];
    string      ek [$];
    logic [1:0] acc;
    logic [1:0] w;
    int c, len, rep;
    los_i = 1'b1; csw_en_i = csw; cal_sel_i = sel; lvds_mode_i = lvds;
    drive_stat();
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk(stat_o, 2'b11, "R11", {tag, " los idle"});
    end
    los_i = 1'b0;
    for (int f = 0; f < nfr; f++) begin
      if (csw) m_cur = int'(sel);
      c = m_cur;
      len = lvds ? (m_len[c] | 3) : m_len[c];
      rep = m_rep[c];
      ew.delete(); ek.delete(); acc = 2'b00;
      ew.push_back(2'b11); ek.push_back("R5 framing");
      if (csw) begin
        w = {1'b0, c[0]};
        ew.push_back(w); ek.push_back("R7 select");
        acc = {acc[0], acc[1]} ^ w;
      end
      for (int r = 0; r <= rep; r++)
        for (int s = 0; s <= len; s++) begin
          w = m_stat[m_ent[c][s]];
          ew.push_back(w); ek.push_back("R2 slot");
          acc = {acc[0], acc[1]} ^ w;
        end
      ew.push_back(~acc); ek.push_back("R6 dip");
      for (int i = 0; i < ew.size(); i++) begin
        if (f == act_f && i == act_w) begin
          wr_en_i = 1'b1; wr_cal_i = act_c[0]; wr_field_i = act_fld[1:0];
          wr_idx_i = act_i[LW-1:0]; wr_data_i = act_d[7:0];
          mdl_wr(act_c, act_fld, act_i, act_d);
        end
        @(posedge clk_i); @(negedge clk_i);
        wr_en_i = 1'b0;
        chk(stat_o, ew[i], ek[i], $sformatf("%s frame %0d word %0d", tag, f, i));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20061));
    for (int c = 0; c < 2; c++) begin
      m_len[c] = 7; m_rep[c] = 1;
      for (int i = 0; i < MS; i++) m_ent[c][i] = i % NP;
    end
    for (int p = 0; p < NP; p++) m_stat[p] = 2'(p % 4);
    repeat (3) @(negedge clk_i);
    chk(stat_o, 2'b11, "R1", "in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(stat_o, 2'b11, "R1", "after reset");

    // R1 default calendar 0: 8 slots, 2 passes
    run_stream(2, 1'b0, 1'b0, 1'b0, -1, 0, 0, 0, 0, 0, "R1 defaults");
    // R3 R4 length and repeat
    do_wr(0, 1, 0, 4);
    do_wr(0, 0, 0, 2);
    run_stream(2, 1'b0, 1'b0, 1'b0, -1, 0, 0, 0, 0, 0, "R3 R4 len rep");
    // R9 differential rounding: 4 -> 7
    run_stream(2, 1'b0, 1'b0, 1'b1, -1, 0, 0, 0, 0, 0, "R9 lvds");
    // R8 independent calendar 1, R7 selection
    do_wr(1, 1, 0, 2);
    do_wr(1, 0, 0, 0);
    do_wr(1, 2, 0, 9);
    do_wr(1, 2, 1, 3);
    do_wr(1, 2, 2, 12);
    run_stream(2, 1'b1, 1'b1, 1'b0, -1, 0, 0, 0, 0, 0, "R7 R8 cal1");
    run_stream(2, 1'b0, 1'b0, 1'b0, -1, 0, 0, 0, 0, 0, "R7 hold without switch");
    run_stream(2, 1'b1, 1'b0, 1'b0, 0, 4, 1, 1, 0, 5, "R8 write to idle cal");
    // R10 mid-frame write and write on the framing edge
    run_stream(3, 1'b0, 1'b0, 1'b0, 0, 3, 0, 1, 0, 1, "R10 mid-frame");
    run_stream(3, 1'b0, 1'b0, 1'b0, 1, 0, 0, 0, 0, 3, "R10 framing edge");
    run_stream(3, 1'b1, 1'b0, 1'b0, 1, 0, 0, 2, 0, 13, "R10 entry on edge");
    // R12 null field
    run_stream(2, 1'b0, 1'b0, 1'b0, 0, 2, 0, 3, 0, 0, "R12 null write");

    for (int it = 0; it < 25; it++) begin
      int nf, af, aw;
      for (int c = 0; c < 2; c++) begin
        do_wr(c, 1, 0, int'($urandom_range(0, 11)));
        do_wr(c, 0, 0, int'($urandom_range(0, 3)));
        for (int s = 0; s < 16; s++) do_wr(c, 2, s, int'($urandom_range(0, NP - 1)));
      end
      for (int p = 0; p < NP; p++) m_stat[p] = 2'($urandom_range(0, 3));
      nf = int'($urandom_range(2, 3));
      af = int'($urandom_range(0, 2));
      aw = int'($urandom_range(0, 6));
      run_stream(nf, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 af, aw, int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 11)), "R2 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule